// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates four interrupt request lines for a simple processor model. Each line has a fixed rank, and rank 0 is the most urgent. A request sets a pending bit. Pending bits are examined only at instruction boundaries, which an input strobe marks. The most urgent pending request that is currently allowed is taken.

Taking a request saves the whole visible register set as one frame on a last-in, first-out stack. The set is the program counter, the accumulator, four general registers, the interrupt-enable flag and the active rank. The block then jumps to a per-source vector. The length of each service routine comes from a per-source down-counter, whose length is picked from three choices per source. When that counter runs out, the top frame is popped and every saved register is restored. A more urgent request may interrupt a running routine, but only when nesting is switched on.

The user-mode program counter only counts instruction strobes. No real instructions or memory are modelled. A per-source automatic generator can raise requests on a fixed period, which helps to build nesting scenarios.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Among the allowed pending sources, the one with the smallest index is taken (0 = emergency, 1 = disk completion, 2 = timer, 3 = keyboard).
- R2: A source is taken only in a cycle where `instr_stb` is high. No source is taken in a cycle where a routine completes.
- R3: Source 0 is taken whatever the interrupt-enable flag says. Sources 1 to 3 are taken only while the flag is 1.
- R4: Taking source s pushes one frame, loads the program counter with 0x2000 + 0x100*s, loads r0 with s and makes s the active rank. While a routine runs, each strobe that takes no source adds one to both the program counter and the accumulator.
- R5: While a routine runs, a request interrupts it only if `nest_en` is 1 and the request's index is strictly smaller than the active rank.
- R6: The service length in clock cycles is set by the 2-bit field `len_sel[2s+1:2s]`, read at the time source s is taken. Values 0, 1 and 2 pick the short, middle and long length, and value 3 acts as 2. The lengths are 3/5/8 for source 0, 4/6/9 for source 1, 2/4/7 for source 2 and 2/4/6 for source 3. The counter runs only while its routine is the active one, and the routine completes in the clock cycle in which the counter would step from 1 to 0.
- R7: On completion the top frame is popped, and the program counter, accumulator, r0 to r3, the interrupt-enable flag and the active rank all return to their saved values.
- R8: A request on a source that is already pending merges into the existing bit. When a source is taken, its bit is cleared in that same cycle, even if a new request for it arrives in that cycle.
- R9: The stack holds `DEPTH` frames. If a source is selected while the stack is full, the source is not taken, it stays pending, the stored frames are left unchanged and `ovf_err_o` is set and stays set until reset.
- R10: Reset clears every pending bit and every automatic enable, empties the stack and clears the error flag. It sets pc 0x1000, acc 0x00, r0 0x12, r1 0x34, r2 0x56, r3 0x78, the interrupt-enable flag to 1 and the active rank to none.
- R11: `depth_o` reports the number of stored frames and `pend_cnt_o` the number of pending bits. `cur_prio_o` reports the active rank, and reads 4 exactly when the stack is empty.
- R12: A free-running counter starts at 0 after reset and ticks once every `AUTO_PERIOD` cycles. The first tick falls in the cycle that ends `AUTO_PERIOD` cycles after reset. Each source whose automatic enable is 1 becomes pending on a tick. `auto_on` sets enables and `auto_off` clears them, and `auto_off` wins over `auto_on`.
- R13: `ien_wr` loads the interrupt-enable flag from `ien_val`, except in a completion cycle, where the restored value wins.
- R14: In user mode, each strobe that takes no source adds one to the program counter, and the accumulator is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_stb | input | 1 | Marks an instruction boundary |
| irq_trig | input | 4 | Request pulse for each source |
| auto_on | input | 4 | Sets the automatic enable for each source |
| auto_off | input | 4 | Clears the automatic enable for each source |
| len_sel | input | 8 | 2-bit service length choice for each source |
| ien_wr | input | 1 | Write strobe for the interrupt-enable flag |
| ien_val | input | 1 | Value written into the interrupt-enable flag |
| nest_en | input | 1 | Allows preemption by a more urgent source |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| r0_o | output | 8 | General register 0 |
| r1_o | output | 8 | General register 1 |
| r2_o | output | 8 | General register 2 |
| r3_o | output | 8 | General register 3 |
| ien_o | output | 1 | Interrupt-enable flag |
| cur_prio_o | output | 3 | Active rank, 4 when in user mode |
| depth_o | output | 3 | Number of stored frames |
| pend_cnt_o | output | 3 | Number of pending sources |
| pend_o | output | 4 | Pending bits |
| auto_en_o | output | 4 | Automatic enable bits |
| ovf_err_o | output | 1 | Sticky stack-full error |

## Verification
The assertions assume that `rst_n` is released synchronously and that every input is stable around the clock edge. They also assume that `len_sel` never drives a routine length below two cycles, which the length table already guarantees. The stimulus changes inputs only on the falling edge and keeps each pulse input high for exactly one cycle. It drives `len_sel` with arbitrary values, so the code 3 (which acts as 2) is exercised. A second instance with a one-frame stack is driven by the same inputs so that the stack-full path is reached.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NSRC = 4;
  localparam int SW   = 2;
  localparam int PRW  = 3;
  localparam int DW   = 8;
  localparam int AW   = 16;
  localparam int LW   = 4;

  localparam logic [PRW-1:0] PRIO_NONE = 3'd4;
  localparam logic [AW-1:0]  USER_PC   = 16'h1000;
  localparam logic [AW-1:0]  VEC_BASE  = 16'h2000;
  localparam logic [AW-1:0]  VEC_STEP  = 16'h0100;
  localparam logic [DW-1:0]  ACC_INIT  = 8'h00;
  localparam logic [DW-1:0]  R0_INIT   = 8'h12;
  localparam logic [DW-1:0]  R1_INIT   = 8'h34;
  localparam logic [DW-1:0]  R2_INIT   = 8'h56;
  localparam logic [DW-1:0]  R3_INIT   = 8'h78;

  typedef struct packed {
    logic [AW-1:0]  pc;
    logic [DW-1:0]  acc;
    logic [DW-1:0]  r0;
    logic [DW-1:0]  r1;
    logic [DW-1:0]  r2;
    logic [DW-1:0]  r3;
    logic           ien;
    logic [PRW-1:0] prio;
  } frame_t;

  // service length in clock cycles; selector 3 behaves as 2
  function automatic logic [LW-1:0] svc_len(input logic [SW-1:0] src,
                                             input logic [1:0] sel);
    logic [1:0] s;
    s = (sel == 2'd3) ? 2'd2 : sel;
    case ({src, s})
      4'b00_00: svc_len = 4'd3;
      4'b00_01: svc_len = 4'd5;
      4'b00_10: svc_len = 4'd8;
      4'b01_00: svc_len = 4'd4;
      4'b01_01: svc_len = 4'd6;
      4'b01_10: svc_len = 4'd9;
      4'b10_00: svc_len = 4'd2;
      4'b10_01: svc_len = 4'd4;
      4'b10_10: svc_len = 4'd7;
      4'b11_00: svc_len = 4'd2;
      4'b11_01: svc_len = 4'd4;
      default:  svc_len = 4'd6;
    endcase
  endfunction

  function automatic logic [AW-1:0] vec_of(input logic [SW-1:0] src);
    vec_of = VEC_BASE + VEC_STEP * AW'(src);
  endfunction
endpackage

// File: rtl/nic_pending.sv
module nic_pending
  import nic_pkg::*;
#(
  parameter int PERIOD = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] trig,
  input  logic [NSRC-1:0] auto_on,
  input  logic [NSRC-1:0] auto_off,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] auto_en,
  output logic            tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] tcnt;

  assign tick = (tcnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt    <= '0;
      auto_en <= '0;
      pend    <= '0;
    end else begin
      tcnt    <= tick ? '0 : tcnt + 1'b1;
      auto_en <= (auto_en | auto_on) & ~auto_off;
      pend    <= (pend | trig | (auto_en & {NSRC{tick}})) & ~clr;
    end
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic            ien,
  input  logic            nest_en,
  input  logic [PRW-1:0]  cur_prio,
  output logic            have,
  output logic [SW-1:0]   src
);
  logic [NSRC-1:0] allow;
  logic            idle;

  assign idle = (cur_prio == PRIO_NONE);

  for (genvar i = 0; i < NSRC; i++) begin : g_allow
    if (i == 0) begin : g_nmi
      assign allow[i] = pend[i] & (idle | (nest_en & (PRW'(i) < cur_prio)));
    end else begin : g_mask
      assign allow[i] = pend[i] & ien & (idle | (nest_en & (PRW'(i) < cur_prio)));
    end
  end

  always_comb begin
    have = 1'b0;
    src  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (allow[i]) begin
        have = 1'b1;
        src  = SW'(i);
      end
    end
  end
endmodule

// File: rtl/nic_frame_stack.sv
module nic_frame_stack
  import nic_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int DPW = $clog2(DEPTH + 1),
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  frame_t         din,
  output frame_t         top,
  output logic [DPW-1:0] depth,
  output logic           full
);
  frame_t         mem [DEPTH];
  logic [IW-1:0]  wr_idx;
  logic [IW-1:0]  rd_idx;

  assign full   = (depth == DPW'(DEPTH));
  assign wr_idx = IW'(depth);
  assign rd_idx = (depth == '0) ? '0 : IW'(depth - 1'b1);
  assign top    = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
    end else if (push && !full) begin
      depth <= depth + 1'b1;
    end else if (pop && depth != '0) begin
      depth <= depth - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= din;
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int AUTO_PERIOD = 20,
  localparam int DPW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_stb,
  input  logic [NSRC-1:0] irq_trig,
  input  logic [NSRC-1:0] auto_on,
  input  logic [NSRC-1:0] auto_off,
  input  logic [2*NSRC-1:0] len_sel,
  input  logic            ien_wr,
  input  logic            ien_val,
  input  logic            nest_en,
  output logic [AW-1:0]   pc_o,
  output logic [DW-1:0]   acc_o,
  output logic [DW-1:0]   r0_o,
  output logic [DW-1:0]   r1_o,
  output logic [DW-1:0]   r2_o,
  output logic [DW-1:0]   r3_o,
  output logic            ien_o,
  output logic [PRW-1:0]  cur_prio_o,
  output logic [DPW-1:0]  depth_o,
  output logic [2:0]      pend_cnt_o,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] auto_en_o,
  output logic            ovf_err_o
);
  // architectural state
  logic [AW-1:0]  pc_q;
  logic [DW-1:0]  acc_q, r0_q, r1_q, r2_q, r3_q;
  logic           ien_q;
  logic [PRW-1:0] cur_prio;
  logic           ovf_q;
  logic [LW-1:0]  tmr [NSRC];

  // named internal events
  logic            in_isr;
  logic            cand_have;
  logic [SW-1:0]   acc_src;
  logic            acc_evt;
  logic            ret_evt;
  logic            ovf_evt;
  logic            stk_full;
  logic [DPW-1:0]  depth;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] auto_en;
  logic [NSRC-1:0] clr_mask;
  logic            auto_tick;
  frame_t          cur_frame;
  frame_t          top_frame;

  assign in_isr  = (cur_prio != PRIO_NONE);
  assign ret_evt = in_isr && (tmr[cur_prio[SW-1:0]] == LW'(1));
  assign acc_evt = instr_stb && cand_have && !ret_evt && !stk_full;
  assign ovf_evt = instr_stb && cand_have && !ret_evt && stk_full;

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    assign clr_mask[i] = acc_evt && (acc_src == SW'(i));
  end

  assign cur_frame = '{pc: pc_q, acc: acc_q, r0: r0_q, r1: r1_q, r2: r2_q,
                       r3: r3_q, ien: ien_q, prio: cur_prio};

  nic_pending #(.PERIOD(AUTO_PERIOD)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (irq_trig),
    .auto_on  (auto_on),
    .auto_off (auto_off),
    .clr      (clr_mask),
    .pend     (pend),
    .auto_en  (auto_en),
    .tick     (auto_tick)
  );

  nic_arbiter u_arb (
    .pend     (pend),
    .ien      (ien_q),
    .nest_en  (nest_en),
    .cur_prio (cur_prio),
    .have     (cand_have),
    .src      (acc_src)
  );

  nic_frame_stack #(.DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (acc_evt),
    .pop   (ret_evt),
    .din   (cur_frame),
    .top   (top_frame),
    .depth (depth),
    .full  (stk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= USER_PC;
      acc_q    <= ACC_INIT;
      r0_q     <= R0_INIT;
      r1_q     <= R1_INIT;
      r2_q     <= R2_INIT;
      r3_q     <= R3_INIT;
      ien_q    <= 1'b1;
      cur_prio <= PRIO_NONE;
      ovf_q    <= 1'b0;
    end else begin
      if (ret_evt) begin
        pc_q     <= top_frame.pc;
        acc_q    <= top_frame.acc;
        r0_q     <= top_frame.r0;
        r1_q     <= top_frame.r1;
        r2_q     <= top_frame.r2;
        r3_q     <= top_frame.r3;
        ien_q    <= top_frame.ien;
        cur_prio <= top_frame.prio;
      end else begin
        if (acc_evt) begin
          pc_q     <= vec_of(acc_src);
          r0_q     <= DW'(acc_src);
          cur_prio <= {1'b0, acc_src};
        end else if (instr_stb) begin
          pc_q <= pc_q + 1'b1;
          if (in_isr) acc_q <= acc_q + 1'b1;
        end
        if (ien_wr) ien_q <= ien_val;
      end
      if (ovf_evt) ovf_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_tmr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmr[i] <= '0;
      end else if (acc_evt && acc_src == SW'(i)) begin
        tmr[i] <= svc_len(SW'(i), len_sel[2*i +: 2]);
      end else if (in_isr && !acc_evt && cur_prio == PRW'(i)) begin
        tmr[i] <= tmr[i] - 1'b1;
      end
    end
  end

  assign pc_o       = pc_q;
  assign acc_o      = acc_q;
  assign r0_o       = r0_q;
  assign r1_o       = r1_q;
  assign r2_o       = r2_q;
  assign r3_o       = r3_q;
  assign ien_o      = ien_q;
  assign cur_prio_o = cur_prio;
  assign depth_o    = depth;
  assign pend_cnt_o = 3'($countones(pend));
  assign pend_o     = pend;
  assign auto_en_o  = auto_en;
  assign ovf_err_o  = ovf_q;
endmodule

// File: rtl/nic_checks.sv
module nic_checks
  import nic_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int DPW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_stb,
  input logic            nest_en,
  input logic            acc_evt,
  input logic            ret_evt,
  input logic [SW-1:0]   acc_src,
  input logic            ien_q,
  input logic [PRW-1:0]  cur_prio,
  input logic [DPW-1:0]  depth,
  input logic [NSRC-1:0] pend,
  input logic            ovf_q
);
  // R11
  idle_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) == (cur_prio == PRIO_NONE));

  // R4
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> (depth == $past(depth) + 1'b1) && (cur_prio == {1'b0, $past(acc_src)}));

  // R7
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_evt |=> depth == $past(depth) - 1'b1);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DPW'(DEPTH));

  // R9
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R3
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && !ien_q) |-> acc_src == '0);

  // R5
  nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && cur_prio != PRIO_NONE) |-> (nest_en && {1'b0, acc_src} < cur_prio));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> !pend[$past(acc_src)]);

  // R2
  boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt || ret_evt) |-> !(acc_evt && ret_evt) && (!acc_evt || instr_stb));
endmodule

bind nest_irq_ctrl nic_checks #(.DEPTH(DEPTH)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .instr_stb (instr_stb),
  .nest_en   (nest_en),
  .acc_evt   (acc_evt),
  .ret_evt   (ret_evt),
  .acc_src   (acc_src),
  .ien_q     (ien_q),
  .cur_prio  (cur_prio),
  .depth     (depth),
  .pend      (pend),
  .ovf_q     (ovf_q)
);

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
  localparam int PER = 20;
  localparam int DEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic [3:0] trig = '0, aon = '0, aoff = '0;
  logic [7:0] lsel = '0;
  logic iwr = 1'b0, ival = 1'b0, nest = 1'b0;

  logic [15:0] pc;
  logic [7:0]  acc, r0, r1, r2, r3;
  logic        ien, ovf;
  logic [2:0]  prio, depth, pcnt;
  logic [3:0]  pend, aen;

  logic [15:0] pc_s;
  logic [7:0]  acc_s, r0_s, r1_s, r2_s, r3_s;
  logic        ien_s, ovf_s;
  logic [2:0]  prio_s, pcnt_s;
  logic [0:0]  depth_s;
  logic [3:0]  pend_s, aen_s;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nest_irq_ctrl #(.DEPTH(DEP), .AUTO_PERIOD(PER)) uut (
    .clk(clk), .rst_n(rst_n), .instr_stb(stb), .irq_trig(trig),
    .auto_on(aon), .auto_off(aoff), .len_sel(lsel), .ien_wr(iwr),
    .ien_val(ival), .nest_en(nest), .pc_o(pc), .acc_o(acc), .r0_o(r0),
    .r1_o(r1), .r2_o(r2), .r3_o(r3), .ien_o(ien), .cur_prio_o(prio),
    .depth_o(depth), .pend_cnt_o(pcnt), .pend_o(pend), .auto_en_o(aen),
    .ovf_err_o(ovf));

  nest_irq_ctrl #(.DEPTH(1), .AUTO_PERIOD(PER)) uut_small (
    .clk(clk), .rst_n(rst_n), .instr_stb(stb), .irq_trig(trig),
    .auto_on(aon), .auto_off(aoff), .len_sel(lsel), .ien_wr(iwr),
    .ien_val(ival), .nest_en(nest), .pc_o(pc_s), .acc_o(acc_s), .r0_o(r0_s),
    .r1_o(r1_s), .r2_o(r2_s), .r3_o(r3_s), .ien_o(ien_s), .cur_prio_o(prio_s),
    .depth_o(depth_s), .pend_cnt_o(pcnt_s), .pend_o(pend_s), .auto_en_o(aen_s),
    .ovf_err_o(ovf_s));

  // ---------------- behavioural reference ----------------
  typedef struct {
    int pc, acc, r0, r1, r2, r3, ien, prio;
  } ctx_t;

  ctx_t m;
  ctx_t stk[$];
  int m_pend[4];
  int m_auto[4];
  int m_tmr[4];
  int m_tc, m_ovf;
  int lens[4][3] = '{'{3, 5, 8}, '{4, 6, 9}, '{2, 4, 7}, '{2, 4, 6}};

  task automatic model_reset();
    m = '{pc: 'h1000, acc: 0, r0: 'h12, r1: 'h34, r2: 'h56, r3: 'h78, ien: 1, prio: 4};
    stk.delete();
    for (int i = 0; i < 4; i++) begin
      m_pend[i] = 0; m_auto[i] = 0; m_tmr[i] = 0;
    end
    m_tc = 0; m_ovf = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      int tick, busy, ret, cand, take, old_prio, sel;
      ctx_t f;
      tick = (m_tc == PER - 1);
      busy = (m.prio != 4);
      old_prio = m.prio;
      ret = busy && (m_tmr[m.prio] == 1);
      cand = -1;
      for (int i = 0; i < 4; i++)
        if (cand < 0 && m_pend[i] != 0 && (i == 0 || m.ien != 0) &&
            (!busy || (nest && i < m.prio)))
          cand = i;
      take = stb && cand >= 0 && !ret && stk.size() < DEP;
      if (stb && cand >= 0 && !ret && stk.size() >= DEP) m_ovf = 1;
      if (busy && !take) m_tmr[old_prio] = m_tmr[old_prio] - 1;
      if (ret) begin
        f = stk.pop_back();
        m = f;
      end else begin
        if (take) begin
          stk.push_back(m);
          m.pc = 'h2000 + 'h100 * cand;
          m.r0 = cand;
          m.prio = cand;
          sel = int'(lsel[2*cand +: 2]);
          if (sel > 2) sel = 2;
          m_tmr[cand] = lens[cand][sel];
        end else if (stb) begin
          m.pc = (m.pc + 1) & 'hFFFF;
          if (busy) m.acc = (m.acc + 1) & 'hFF;
        end
        if (iwr) m.ien = ival;
      end
      for (int i = 0; i < 4; i++) begin
        if (trig[i] || (m_auto[i] != 0 && tick)) m_pend[i] = 1;
        if (take && cand == i) m_pend[i] = 0;
      end
      for (int i = 0; i < 4; i++) begin
        if (aon[i]) m_auto[i] = 1;
        if (aoff[i]) m_auto[i] = 0;
      end
      m_tc = tick ? 0 : m_tc + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pend_vec();
    return m_pend[0] + 2 * m_pend[1] + 4 * m_pend[2] + 8 * m_pend[3];
  endfunction

  function automatic int auto_vec();
    return m_auto[0] + 2 * m_auto[1] + 4 * m_auto[2] + 8 * m_auto[3];
  endfunction

  // compare two time units after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        chk("R1 R2 R4 R14 pc", int'(pc), m.pc);
        chk("R4 R7 acc", int'(acc), m.acc);
        chk("R4 R7 r0", int'(r0), m.r0);
        chk("R7 r1", int'(r1), m.r1);
        chk("R7 r2", int'(r2), m.r2);
        chk("R7 r3", int'(r3), m.r3);
        chk("R7 R13 ien", int'(ien), m.ien);
        chk("R3 R5 R6 R11 prio", int'(prio), m.prio);
        chk("R7 R11 depth", int'(depth), stk.size());
        chk("R8 R12 pend", int'(pend), pend_vec());
        chk("R11 pend count", int'(pcnt), $countones(pend_vec()));
        chk("R12 auto", int'(aen), auto_vec());
        chk("R9 err", int'(ovf), m_ovf);
        chk("R9 small depth bound", (int'(depth_s) <= 1) ? 1 : 0, 1);
      end
    end
  end

  task automatic next();
    @(negedge clk);
    stb = 1'b0; trig = '0; aon = '0; aoff = '0; iwr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state at the ports
    chk("R10 pc", int'(pc), 'h1000);
    chk("R10 acc", int'(acc), 0);
    chk("R10 r0", int'(r0), 'h12);
    chk("R10 r1", int'(r1), 'h34);
    chk("R10 r2", int'(r2), 'h56);
    chk("R10 r3", int'(r3), 'h78);
    chk("R10 ien", int'(ien), 1);
    chk("R10 prio", int'(prio), 4);
    chk("R10 depth", int'(depth), 0);
    chk("R10 pend", int'(pend), 0);

    // R14 user-mode counting
    for (int k = 0; k < 5; k++) begin stb = 1'b1; next(); end
    chk("R14 pc after five strobes", int'(pc), 'h1005);

    // R1 R8 two requests, nesting off, merged retrigger
    trig = 4'b1010; next();
    trig = 4'b1000; next();
    lsel = 8'b00_00_10_00;
    stb = 1'b1; next();
    chk("R1 disk first", int'(prio), 1);
    chk("R4 vector", int'(pc), 'h2100);
    for (int k = 0; k < 30; k++) begin stb = 1'(k % 2); next(); end

    // R3 mask off: only emergency taken
    iwr = 1'b1; ival = 1'b0; next();
    trig = 4'b0101; next();
    stb = 1'b1; next();
    chk("R3 emergency taken while masked", int'(prio), 0);
    for (int k = 0; k < 20; k++) begin stb = 1'b1; next(); end
    chk("R3 timer still pending", int'(pend[2]), 1);
    iwr = 1'b1; ival = 1'b1; next();
    for (int k = 0; k < 30; k++) begin stb = 1'b1; next(); end

    // drain both instances
    for (int k = 0; k < 200; k++) begin
      if (pend == 0 && depth == 0 && pend_s == 0 && depth_s == 0) break;
      stb = 1'b1; next();
    end

    // R5 R9 nesting chain; small instance overflows
    nest = 1'b1; lsel = 8'hFF;
    trig = 4'b1000; next();
    stb = 1'b1; next();
    trig = 4'b0001; next();
    stb = 1'b1; next();
    chk("R5 emergency preempts keyboard", int'(prio), 0);
    chk("R9 small error set", int'(ovf_s), 1);
    chk("R9 small depth kept", int'(depth_s), 1);
    trig = 4'b0110; next();
    for (int k = 0; k < 60; k++) begin stb = 1'(k % 3 != 0); next(); end
    chk("R9 small error sticky", int'(ovf_s), 1);

    // R12 automatic generation with nesting
    aon = 4'b1111; next();
    for (int k = 0; k < 3000; k++) begin
      stb = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 7) == 0) trig = 4'($urandom_range(0, 15));
      lsel = 8'($urandom);
      if ($urandom_range(0, 40) == 0) begin iwr = 1'b1; ival = 1'($urandom_range(0, 1)); end
      if ($urandom_range(0, 200) == 0) nest = ~nest;
      if ($urandom_range(0, 300) == 0) aoff = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 300) == 0) aon = 4'($urandom_range(0, 15));
      next();
    end
    aoff = 4'b1111; aon = 4'b0001; next();
    chk("R12 off wins over on", int'(aen), 0);
    for (int k = 0; k < 200; k++) begin stb = 1'b1; iwr = (k == 0); ival = 1'b1; next(); end
    finish_run();
  end
endmodule